// File: doc/BRIEF.md
# Dual Line-Clock Activity Watchdog

This block watches two serial clock lines that arrive from outside the chip, one for the transmit direction and one for the receive direction. It reports when a line has stopped toggling. Each direction has its own timer, which counts cycles of the local system clock. A 2-bit select input either turns the timer off or picks one of three power-of-two timeout lengths. Any change of level on the watched line starts the count again from zero. If the count reaches the selected length with no change seen, the direction raises a one-cycle expiry pulse. It also sets a sticky flag, which stays set until the shared clear input is raised.

Each line first passes through a two-flop synchronizer. A change in the synchronized level counts as activity. After it fires, a timer stays quiet until its line moves again or its select code changes. Each direction runs a three-state machine: `ST_OFF` (disabled), `ST_RUN` (counting) and `ST_HOLD` (expired, waiting). The transitions are:
- `restart`: any select change. It goes to `ST_OFF` for code 00 and to `ST_RUN` otherwise, from any state.
- `activity`: a line change. In `ST_RUN` or `ST_HOLD` it goes to `ST_RUN` with the count cleared.
- `timeout`: `ST_RUN` to `ST_HOLD`, together with the pulse.

The parameter `LIMIT_LOG2_MIN` (default 18) sets the shortest timeout.

Top module: `lcw_dual_watchdog`

## Requirements
- R1: The transmit and receive timers are independent. Each uses only its own line and its own select code, and drives only its own pulse and flag.
- R2: Select code 00 disables a direction. It never pulses, and its flag is never set.
- R3: Let B be `LIMIT_LOG2_MIN`. Code 01 gives a limit L of 2^B cycles, code 10 gives 2^(B+1) and code 11 gives 2^(B+2). The default B of 18 gives 2^18, 2^19 and 2^20.
- R4: A rising edge on a line restarts that direction's count, and so does a falling edge. The edge reaches the timer through a two-flop synchronizer. If the line changes before clock edge k and then stays still, the pulse is high in the cycle after edge k+2+L.
- R5: A select change to a nonzero code, applied before clock edge k, restarts the count. The pulse is then high in the cycle after edge k+L.
- R6: The expiry pulse lasts exactly one cycle. The direction does not pulse again until a line change or a select change restarts it.
- R7: A direction's sticky flag goes high on the same clock edge as its pulse. It stays high until it is cleared. A pulse on the same edge as a clear wins, so the flag stays set.
- R8: While reset is held, both pulses and both flags are low and both timers are off.
- R9: When the clear input is high at a clock edge, every flag without a pulse on that edge becomes low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all counting is in its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_line_i | input | 1 | Watched transmit line clock (asynchronous) |
| rx_line_i | input | 1 | Watched receive line clock (asynchronous) |
| tx_sel_i | input | 2 | Transmit timeout code: 00 off, 01/10/11 limits |
| rx_sel_i | input | 2 | Receive timeout code: 00 off, 01/10/11 limits |
| clr_i | input | 1 | Clears both sticky flags |
| tx_expire_o | output | 1 | One-cycle transmit expiry pulse |
| rx_expire_o | output | 1 | One-cycle receive expiry pulse |
| tx_stuck_o | output | 1 | Sticky transmit expiry flag |
| rx_stuck_o | output | 1 | Sticky receive expiry flag |

## Verification
A pulse is due L+1 clock edges after a select change, and L+3 edges after a line change, because the two synchronizer flops and the edge register add two edges. The bench changes inputs only on falling clock edges. At each such change it records the cycle number, and it queues the expected pulse cycle only for the last stimulus before a quiet period. A monitor reads the outputs on every falling edge. It matches each pulse against the head of that direction's queue by exact cycle, and any pulse that arrives with nothing queued is a failure. Flags are read one falling edge after the clock edge that should change them.

// File: rtl/lcw_pkg.sv
package lcw_pkg;

    localparam int NUM_DIR = 2;
    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;
    localparam int SEL_W   = 2;

    typedef logic [SEL_W-1:0] sel_t;

    localparam sel_t SEL_OFF = 2'b00;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_RUN  = 2'b01,
        ST_HOLD = 2'b10
    } wd_state_t;

endpackage

// File: rtl/lcw_edge_sync.sv
module lcw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic change_o
);
    localparam int SR_W = STAGES + 1;

    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[SR_W-2:0], line_i};
        end
    end

    // Synchronized level differs from the level one cycle older.
    assign change_o = sr_q[STAGES] ^ sr_q[STAGES-1];

endmodule

// File: rtl/lcw_timer.sv
module lcw_timer
    import lcw_pkg::*;
#(
    parameter int LIMIT_LOG2_MIN = 18
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  sel_t sel_i,
    input  logic change_i,
    output logic fire_o,
    output logic pulse_o
);
    localparam int CNT_W = LIMIT_LOG2_MIN + 3;
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST1 = (ONE << LIMIT_LOG2_MIN) - ONE;
    localparam logic [CNT_W-1:0] LAST2 = (ONE << (LIMIT_LOG2_MIN + 1)) - ONE;
    localparam logic [CNT_W-1:0] LAST3 = (ONE << (LIMIT_LOG2_MIN + 2)) - ONE;

    wd_state_t        state_q, state_d;
    sel_t             sel_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_cnt;
    logic             restart;
    logic             at_limit;
    logic             fire;
    logic             pulse_q;

    always_comb begin
        unique case (sel_q)
            2'b01:   last_cnt = LAST1;
            2'b10:   last_cnt = LAST2;
            2'b11:   last_cnt = LAST3;
            default: last_cnt = '0;
        endcase
    end

    assign restart  = (sel_i != sel_q);
    assign at_limit = (cnt_q == last_cnt);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (restart) begin
            cnt_d   = '0;
            state_d = (sel_i == SEL_OFF) ? ST_OFF : ST_RUN;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    cnt_d = '0;
                end
                ST_RUN: begin
                    if (change_i) begin
                        cnt_d = '0;
                    end else if (at_limit) begin
                        state_d = ST_HOLD;
                        fire    = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                ST_HOLD: begin
                    if (change_i) begin
                        state_d = ST_RUN;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register process.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            sel_q   <= SEL_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_i;
            cnt_q   <= cnt_d;
        end
    end

    // Output process.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
        end
    end

    assign fire_o  = fire;
    assign pulse_o = pulse_q;

endmodule

// File: rtl/lcw_dual_watchdog.sv
module lcw_dual_watchdog
    import lcw_pkg::*;
#(
    parameter int LIMIT_LOG2_MIN = 18,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tx_line_i,
    input  logic       rx_line_i,
    input  logic [1:0] tx_sel_i,
    input  logic [1:0] rx_sel_i,
    input  logic       clr_i,
    output logic       tx_expire_o,
    output logic       rx_expire_o,
    output logic       tx_stuck_o,
    output logic       rx_stuck_o
);
    logic [NUM_DIR-1:0] line_v;
    sel_t               sel_v [NUM_DIR];
    logic [NUM_DIR-1:0] change_v;
    logic [NUM_DIR-1:0] fire_v;
    logic [NUM_DIR-1:0] pulse_v;
    logic [NUM_DIR-1:0] stuck_q;

    assign line_v[DIR_TX] = tx_line_i;
    assign line_v[DIR_RX] = rx_line_i;
    assign sel_v[DIR_TX]  = tx_sel_i;
    assign sel_v[DIR_RX]  = rx_sel_i;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        lcw_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .line_i   (line_v[d]),
            .change_o (change_v[d])
        );

        lcw_timer #(
            .LIMIT_LOG2_MIN (LIMIT_LOG2_MIN)
        ) u_timer (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sel_i    (sel_v[d]),
            .change_i (change_v[d]),
            .fire_o   (fire_v[d]),
            .pulse_o  (pulse_v[d])
        );

        // Set has priority over clear.
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stuck_q[d] <= 1'b0;
            end else if (fire_v[d]) begin
                stuck_q[d] <= 1'b1;
            end else if (clr_i) begin
                stuck_q[d] <= 1'b0;
            end
        end
    end

    assign tx_expire_o = pulse_v[DIR_TX];
    assign rx_expire_o = pulse_v[DIR_RX];
    assign tx_stuck_o  = stuck_q[DIR_TX];
    assign rx_stuck_o  = stuck_q[DIR_RX];

endmodule

// File: rtl/lcw_checker.sv
module lcw_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tx_line_i,
    input logic       rx_line_i,
    input logic [1:0] tx_sel_i,
    input logic [1:0] rx_sel_i,
    input logic       clr_i,
    input logic       tx_expire_o,
    input logic       rx_expire_o,
    input logic       tx_stuck_o,
    input logic       rx_stuck_o
);
    // R2: a disabled direction never pulses on the following edge
    assert_tx_off_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_sel_i == 2'b00 |=> !tx_expire_o);
    assert_rx_off_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_sel_i == 2'b00 |=> !rx_expire_o);

    // R6: pulse is a single cycle
    assert_tx_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_expire_o |=> !tx_expire_o);
    assert_rx_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_expire_o |=> !rx_expire_o);

    // R7: flag set together with pulse, and sticky without clear
    assert_tx_flag_with_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_expire_o |-> tx_stuck_o);
    assert_rx_flag_with_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_expire_o |-> rx_stuck_o);
    assert_tx_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_stuck_o && !clr_i) |=> tx_stuck_o);
    assert_rx_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_stuck_o && !clr_i) |=> rx_stuck_o);

    // R9: clear drops a flag unless a pulse arrives at the same edge
    assert_tx_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (!tx_stuck_o || tx_expire_o));
    assert_rx_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (!rx_stuck_o || rx_expire_o));

    // R8: outputs held low in reset
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            assert_reset_quiet_R8: assert (!tx_expire_o && !rx_expire_o && !tx_stuck_o && !rx_stuck_o);
        end
    end

endmodule

bind lcw_dual_watchdog lcw_checker u_chk (.*);

// File: tb/sim_lcw_dual_watchdog.sv
`timescale 1ns/1ps
module sim_lcw_dual_watchdog;

    localparam int B  = 4;
    localparam int L1 = 1 << B;
    localparam int L2 = 1 << (B + 1);
    localparam int L3 = 1 << (B + 2);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_line = 1'b0;
    logic       rx_line = 1'b0;
    logic [1:0] tx_sel = 2'b00;
    logic [1:0] rx_sel = 2'b00;
    logic       clr = 1'b0;
    logic       tx_exp, rx_exp, tx_stk, rx_stk;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int exp_tx[$];
    int exp_rx[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lcw_dual_watchdog #(.LIMIT_LOG2_MIN(B)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .tx_line_i(tx_line), .rx_line_i(rx_line),
        .tx_sel_i(tx_sel), .rx_sel_i(rx_sel),
        .clr_i(clr),
        .tx_expire_o(tx_exp), .rx_expire_o(rx_exp),
        .tx_stuck_o(tx_stk), .rx_stuck_o(rx_stk)
    );

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: pops expected pulse cycles per direction.
    always @(negedge clk) begin
        if (rst_n && tx_exp) begin
            if (exp_tx.size() == 0) check(1'b0, "R6/R2 tx unexpected pulse", cyc, -1);
            else begin
                int e;
                e = exp_tx.pop_front();
                check(cyc == e, "R3/R4/R5 tx pulse cycle", cyc, e);
            end
        end
        if (rst_n && rx_exp) begin
            if (exp_rx.size() == 0) check(1'b0, "R1/R2 rx unexpected pulse", cyc, -1);
            else begin
                int e;
                e = exp_rx.pop_front();
                check(cyc == e, "R1/R3 rx pulse cycle", cyc, e);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(string req);
        int w = 0;
        while ((exp_tx.size() != 0 || exp_rx.size() != 0) && w < 400) begin
            @(negedge clk);
            w++;
        end
        check(exp_tx.size() == 0 && exp_rx.size() == 0, req,
              exp_tx.size() + exp_rx.size(), 0);
    endtask

    task automatic set_tx(logic [1:0] code, int lim, bit expect_it);
        @(negedge clk);
        tx_sel = code;
        if (expect_it) exp_tx.push_back(cyc + 1 + lim);
    endtask

    task automatic toggle_tx(int lim, bit expect_it);
        @(negedge clk);
        tx_line = ~tx_line;
        if (expect_it) exp_tx.push_back(cyc + 3 + lim);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        step(5);
        // R8: reset state
        check(!tx_exp && !rx_exp, "R8 pulses low in reset", {tx_exp, rx_exp}, 0);
        check(!tx_stk && !rx_stk, "R8 flags low in reset", {tx_stk, rx_stk}, 0);
        rst_n = 1'b1;
        step(3);

        // R3/R5: code 01 after select change; R6: no repeat
        set_tx(2'b01, L1, 1'b1);
        drain("R3 code 01 pulse arrived");
        step(80);
        check(tx_stk == 1'b1, "R7 tx flag set", tx_stk, 1);
        check(rx_stk == 1'b0, "R1 rx flag untouched", rx_stk, 0);

        // R9: clear
        pulse_clr();
        check(tx_stk == 1'b0, "R9 tx flag cleared", tx_stk, 0);

        // R4: rising edge restarts from hold
        toggle_tx(L1, 1'b1);
        drain("R4 rising edge pulse");

        // R4: repeated edges keep restarting; last edge falling
        for (int i = 0; i < 9; i++) begin
            toggle_tx(L1, i == 8);
            if (i != 8) step(7);
        end
        drain("R4 falling edge pulse");
        check(tx_line == 1'b0, "R4 last edge was falling", tx_line, 0);

        // R3: other codes
        set_tx(2'b10, L2, 1'b1);
        drain("R3 code 10 pulse");
        set_tx(2'b11, L3, 1'b1);
        drain("R3 code 11 pulse");

        // R5: code change mid-count restarts
        set_tx(2'b01, L1, 1'b0);
        step(10);
        set_tx(2'b10, L2, 1'b1);
        drain("R5 mid-count change");
        step(20);

        // R2: disabled never fires, even with line activity
        set_tx(2'b00, 0, 1'b0);
        pulse_clr();
        step(150);
        toggle_tx(0, 1'b0);
        step(120);
        check(tx_stk == 1'b0 && rx_stk == 1'b0, "R2 flags stay low when off",
              {tx_stk, rx_stk}, 0);

        // R1: both directions at once with different codes
        @(negedge clk);
        tx_sel = 2'b01;
        rx_sel = 2'b11;
        exp_tx.push_back(cyc + 1 + L1);
        step(30);
        @(negedge clk);
        rx_line = ~rx_line;
        exp_rx.push_back(cyc + 3 + L3);
        drain("R1 independent pulses");
        check(tx_stk && rx_stk, "R1 both flags set", {tx_stk, rx_stk}, 3);

        // R7: set wins over clear at the same edge; R9 clears rx
        set_tx(2'b00, 0, 1'b0);
        begin
            int c0;
            @(negedge clk);
            tx_sel = 2'b01;
            c0 = cyc;
            exp_tx.push_back(c0 + 1 + L1);
            while (cyc != c0 + L1) @(negedge clk);
            clr = 1'b1;
            @(negedge clk);
            clr = 1'b0;
        end
        check(tx_stk == 1'b1, "R7 set wins over clear", tx_stk, 1);
        check(rx_stk == 1'b0, "R9 rx flag cleared", rx_stk, 0);
        drain("R7 pulse with clear");
        step(10);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule